// File: doc/BRIEF.md
# Backup-Domain Register Save/Recall Sequencer

This block moves a fixed image of thirteen byte-wide configuration slots between the main power domain and a battery-backed domain. A save command sends the main-side bytes out to the backup registers. A recall command brings the backup-side bytes back and writes them into the main-side slot registers. The bytes go over a serial link one at a time. Each byte takes one period of a slow transfer clock, which is the bus clock divided by a programmable divisor.

Software writes two registers. The command register is at config address 0: bit 0 requests a save and bit 1 requests a recall. The divisor register is at config address 1. While an operation runs, the block drives a strobe, a slot index, a direction bit and a data byte toward the backup domain. During a recall it also drives a slot write port toward the main side. The block raises a busy flag for the length of the operation and gives a single-cycle done pulse when the operation ends.

Top module: `bkp_xfer_seq`

## Requirements
- R1: While reset is low and after it is released, `busy`, `done`, `bk_stb`, `main_wr_en` and `cmd_bits` are all 0.
- R2: When idle, a command write with bit 0 set starts a save. On each strobe `bk_dir` is 1 and `bk_wdata` is byte k of `main_img`, which is bits [8k-1:8k-8] for slot k.
- R3: When idle, a command write with only bit 1 set starts a recall. On each strobe `bk_dir` is 0, `main_wr_en` is 1, `main_wr_slot` equals `bk_slot`, and `main_wr_data` equals `bk_rdata`.
- R4: With effective divisor D, the first strobe comes in the D-th cycle of `busy`, and each later strobe comes exactly D bus cycles after the one before it.
- R5: The strobes carry slot numbers 1 to 13 in ascending order. Slot 7 is transferred like any other slot.
- R6: Every operation makes exactly 13 strobes, and `bk_stb` is never high unless `busy` is high.
- R7: A divisor value of 0 behaves as a divisor of 1.
- R8: The divisor is captured when a command is accepted. A divisor write during an operation does not change that operation's timing, but the next operation uses the new value.
- R9: `busy` rises in the cycle after an accepted command write and stays high for 13·D cycles. Command writes made while busy, and command writes with neither bit set, start nothing and leave `cmd_bits` unchanged.
- R10: If bits 0 and 1 are both set in one write, only the save runs, and `cmd_bits` reads 2'b01.
- R11: `cmd_bits` shows the running command (01 for save, 10 for recall) and clears to 0 when the operation ends. `done` is high for exactly one cycle, the cycle after the 13th strobe, and `busy` is low in that cycle.
- R12: `main_wr_en` is high only on a strobe of a recall. It is never high during a save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 1 | Config address: 0 = command, 1 = divisor |
| cfg_wdata | input | 8 | Config write data |
| main_img | input | 104 | Main-side slot bytes; slot k is in bits [8k-1:8k-8] |
| bk_rdata | input | 8 | Byte returned by the backup domain for the slot on `bk_slot` |
| bk_wdata | output | 8 | Byte sent to the backup domain during a save |
| bk_slot | output | 4 | Slot index of the current transfer, 1 to 13 |
| bk_dir | output | 1 | 1 = save (toward backup), 0 = recall |
| bk_stb | output | 1 | One-cycle transfer strobe, one per slot |
| main_wr_en | output | 1 | Main-side slot write enable during a recall |
| main_wr_slot | output | 4 | Main-side slot index being written |
| main_wr_data | output | 8 | Byte written to the main-side slot |
| cmd_bits | output | 2 | Command bits that are pending or running |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Two events can land in the same cycle: a save request and a recall request written together, and a new command write or divisor write arriving while an operation is still running. The bench covers the first by writing both command bits at once. It then checks that only save strobes come out and that `cmd_bits` reads 01. For the second, during a recall it writes a save command and a new divisor. It checks that the scoreboard's slot order and strobe cycles, which were fixed when the command was accepted, still match, and that the following operation runs at the new divisor.

// File: rtl/bkp_xfer_pkg.sv
`timescale 1ns/1ps
package bkp_xfer_pkg;
  localparam logic CFG_ADDR_CMD = 1'b0;
  localparam logic CFG_ADDR_DIV = 1'b1;
  localparam int   CMD_SAVE_BIT = 0;
  localparam int   CMD_RCL_BIT  = 1;

  typedef enum logic {
    DIR_RECALL = 1'b0,
    DIR_SAVE   = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/bkx_tick_gen.sv
`timescale 1ns/1ps
module bkx_tick_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic [DIVW-1:0] div_in,
  output logic            tick
);
  logic [DIVW-1:0] div_q, div_d;
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic            ld_en;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    tick  = 1'b0;
    ld_en = 1'b0;
    if (start) begin
      ld_en = 1'b1;
      div_d = (div_in == '0) ? DIVW'(1) : div_in;
      cnt_d = '0;
    end else if (run) begin
      ld_en = 1'b1;
      if (cnt_q == div_q - DIVW'(1)) begin
        tick  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + DIVW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIVW'(1);
      cnt_q <= '0;
    end else if (ld_en) begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < div_q)); // R4
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_q != '0)); // R7
endmodule

// File: rtl/bkx_slot_ctr.sv
`timescale 1ns/1ps
module bkx_slot_ctr #(
  parameter int NSLOTS = 13,
  parameter int SLOTW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  output logic [SLOTW-1:0] slot,
  output logic             last
);
  logic [SLOTW-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    last   = tick && (idx_q == SLOTW'(NSLOTS));
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (start) begin
      idx_en = 1'b1;
      idx_d  = SLOTW'(1);
    end else if (tick && !last) begin
      idx_en = 1'b1;
      idx_d  = idx_q + SLOTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= SLOTW'(1);
    else if (idx_en) idx_q <= idx_d;
  end

  assign slot = idx_q;

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !last && !start) |=> (idx_q == $past(idx_q) + SLOTW'(1))); // R5
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (idx_q >= SLOTW'(1) && idx_q <= SLOTW'(NSLOTS))); // R5
endmodule

// File: rtl/bkp_xfer_seq.sv
`timescale 1ns/1ps
module bkp_xfer_seq
  import bkp_xfer_pkg::*;
#(
  parameter int NSLOTS = 13,
  parameter int DW     = 8,
  parameter int DIVW   = 8,
  localparam int SLOTW = $clog2(NSLOTS + 1),
  localparam int IMGW  = NSLOTS * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [DIVW-1:0]  cfg_wdata,
  input  logic [IMGW-1:0]  main_img,
  input  logic [DW-1:0]    bk_rdata,
  output logic [DW-1:0]    bk_wdata,
  output logic [SLOTW-1:0] bk_slot,
  output logic             bk_dir,
  output logic             bk_stb,
  output logic             main_wr_en,
  output logic [SLOTW-1:0] main_wr_slot,
  output logic [DW-1:0]    main_wr_data,
  output logic [1:0]       cmd_bits,
  output logic             busy,
  output logic             done
);
  logic            busy_q, busy_d;
  xfer_dir_e       dir_q, dir_d;
  logic [1:0]      cmd_q, cmd_d;
  logic            done_q, done_d;
  logic [DIVW-1:0] div_q, div_d;
  logic            ctl_en, div_en;

  logic cmd_wr, div_wr, req_save, req_rcl, accept;
  logic tick, last;
  logic [SLOTW-1:0] slot;
  logic [DW-1:0] img_b [NSLOTS];

  assign cmd_wr   = cfg_wr && (cfg_addr == CFG_ADDR_CMD);
  assign div_wr   = cfg_wr && (cfg_addr == CFG_ADDR_DIV);
  assign req_save = cmd_wr && cfg_wdata[CMD_SAVE_BIT];
  assign req_rcl  = cmd_wr && cfg_wdata[CMD_RCL_BIT];
  assign accept   = !busy_q && (req_save || req_rcl);

  always_comb begin
    busy_d = busy_q;
    dir_d  = dir_q;
    cmd_d  = cmd_q;
    done_d = busy_q && last;
    ctl_en = 1'b1;
    div_en = div_wr;
    div_d  = cfg_wdata;
    if (accept) begin
      busy_d = 1'b1;
      dir_d  = req_save ? DIR_SAVE : DIR_RECALL;
      cmd_d  = req_save ? 2'b01 : 2'b10;
    end else if (busy_q && last) begin
      busy_d = 1'b0;
      cmd_d  = 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_RECALL;
      cmd_q  <= 2'b00;
      done_q <= 1'b0;
    end else if (ctl_en) begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
      cmd_q  <= cmd_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  bkx_tick_gen #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy_q),
    .div_in(div_q), .tick(tick)
  );

  bkx_slot_ctr #(.NSLOTS(NSLOTS), .SLOTW(SLOTW)) u_slot (
    .clk(clk), .rst_n(rst_n), .start(accept), .tick(tick),
    .slot(slot), .last(last)
  );

  for (genvar g = 0; g < NSLOTS; g++) begin : g_img
    assign img_b[g] = main_img[g*DW +: DW];
  end

  always_comb begin
    bk_wdata = '0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (dir_q == DIR_SAVE && slot == SLOTW'(i + 1)) bk_wdata = img_b[i];
    end
  end

  assign bk_slot      = slot;
  assign bk_dir       = dir_q;
  assign bk_stb       = tick;
  assign main_wr_en   = tick && (dir_q == DIR_RECALL);
  assign main_wr_slot = slot;
  assign main_wr_data = bk_rdata;
  assign cmd_bits     = cmd_q;
  assign busy         = busy_q;
  assign done         = done_q;

  AST_STB_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bk_stb |-> busy); // R6
  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr)); // R9
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !last) |=> (cmd_bits == $past(cmd_bits))); // R9
  AST_SAVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_save && req_rcl) |=> (cmd_bits == 2'b01 && bk_dir)); // R10
  AST_END_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R11
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cmd_bits == 2'b00)); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_WR_ONLY_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    main_wr_en |-> (!bk_dir && bk_stb)); // R12
endmodule

// File: tb/sim_bkp_xfer_seq.sv
`timescale 1ns/1ps
module sim_bkp_xfer_seq;
  localparam int NS = 13;
  localparam int DW = 8;
  localparam int SW = 4;

  typedef struct packed {
    logic          dir;
    logic [SW-1:0] slot;
    logic [DW-1:0] data;
    int            cyc;
  } xfer_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr, cfg_addr;
  logic [7:0] cfg_wdata;
  logic [NS*DW-1:0] main_img;
  logic [DW-1:0] bk_rdata, bk_wdata, main_wr_data;
  logic [SW-1:0] bk_slot, main_wr_slot;
  logic bk_dir, bk_stb, main_wr_en, busy, done;
  logic [1:0] cmd_bits;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cur_div = 0;
  logic [7:0] rd_seed = 8'h00;
  xfer_item_t exp_q[$];
  int done_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rd_byte(input logic [SW-1:0] s, input logic [7:0] sd);
    return {s, 4'h0} ^ 8'h5C ^ sd;
  endfunction

  assign bk_rdata = rd_byte(bk_slot, rd_seed);

  bkp_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .main_img(main_img), .bk_rdata(bk_rdata),
    .bk_wdata(bk_wdata), .bk_slot(bk_slot), .bk_dir(bk_dir), .bk_stb(bk_stb),
    .main_wr_en(main_wr_en), .main_wr_slot(main_wr_slot),
    .main_wr_data(main_wr_data), .cmd_bits(cmd_bits), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input bit ok, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  // monitor: pops scoreboard entries as strobes and done pulses appear
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (bk_stb) begin
        if (exp_q.size() == 0) chk("R6 strobe with empty scoreboard", 0, bk_slot, 0);
        else begin
          xfer_item_t e;
          e = exp_q.pop_front();
          chk("R4 strobe cycle", cyc == e.cyc, cyc, e.cyc);
          chk("R5 slot order", bk_slot == e.slot, bk_slot, e.slot);
          chk("R10 direction", bk_dir == e.dir, bk_dir, e.dir);
          if (e.dir) begin
            chk("R2 save data", bk_wdata == e.data, bk_wdata, e.data);
            chk("R12 no main write on save", main_wr_en == 1'b0, main_wr_en, 0);
          end else begin
            chk("R3 recall write enable", main_wr_en == 1'b1, main_wr_en, 1);
            chk("R3 recall slot", main_wr_slot == e.slot, main_wr_slot, e.slot);
            chk("R3 recall data", main_wr_data == e.data, main_wr_data, e.data);
          end
        end
      end else if (main_wr_en) begin
        chk("R12 main write without strobe", 0, 1, 0);
      end
      if (done) begin
        if (done_q.size() == 0) chk("R11 unexpected done", 0, 1, 0);
        else begin
          int dc;
          dc = done_q.pop_front();
          chk("R11 done cycle", cyc == dc, cyc, dc);
          chk("R11 busy low at done", busy == 1'b0, busy, 0);
        end
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // driver: loads the scoreboard, issues the command, optionally pokes while busy
  task automatic run_op(input logic [1:0] bits, input logic [7:0] seed, input bit poke,
                        input logic [7:0] poke_div);
    int d, c;
    logic sv;
    logic [1:0] exp_cmd;
    d  = (cur_div == 0) ? 1 : cur_div;
    sv = bits[0];
    exp_cmd = sv ? 2'b01 : 2'b10;
    for (int k = 0; k < NS; k++) main_img[k*DW +: DW] = seed + 8'(k * 29);
    rd_seed = seed;
    c = cyc;
    for (int k = 1; k <= NS; k++) begin
      xfer_item_t e;
      e.dir  = sv;
      e.slot = SW'(k);
      e.data = sv ? main_img[(k-1)*DW +: DW] : rd_byte(SW'(k), seed);
      e.cyc  = c + k * d;
      exp_q.push_back(e);
    end
    done_q.push_back(c + NS * d + 1);
    wr(1'b0, {6'd0, bits});
    chk("R9 busy after accept", busy == 1'b1, busy, 1);
    chk("R11 command bits while running", cmd_bits == exp_cmd, cmd_bits, exp_cmd);
    if (poke) begin
      wr(1'b0, 8'h01);
      wr(1'b1, poke_div);
      chk("R9 command write while busy ignored", cmd_bits == exp_cmd, cmd_bits, exp_cmd);
      cur_div = poke_div;
    end
    while (cyc < c + NS * d + 2) @(negedge clk);
    chk("R9 busy cleared", busy == 1'b0, busy, 0);
    chk("R11 command bits cleared", cmd_bits == 2'b00, cmd_bits, 0);
    chk("R6 all 13 strobes seen", exp_q.size() == 0, exp_q.size(), 0);
    chk("R11 done seen", done_q.size() == 0, done_q.size(), 0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    wait (cyc == 20000);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual still running expected finished");
    report();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0; main_img = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy == 1'b0, busy, 0);
    chk("R1 done in reset", done == 1'b0, done, 0);
    chk("R1 strobe in reset", bk_stb == 1'b0, bk_stb, 0);
    chk("R1 cmd bits in reset", cmd_bits == 2'b00, cmd_bits, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", busy == 1'b0 && main_wr_en == 1'b0, busy, 0);

    // R7: divisor 0 behaves as 1; R2 save
    wr(1'b1, 8'd0); cur_div = 0;
    run_op(2'b01, 8'h11, 0, 8'd0);
    // R3 recall, R4 divisor 3
    wr(1'b1, 8'd3); cur_div = 3;
    run_op(2'b10, 8'h33, 0, 8'd0);
    // R10 both bits: save wins
    wr(1'b1, 8'd2); cur_div = 2;
    run_op(2'b11, 8'h5A, 0, 8'd0);
    // R8/R9 writes during a recall do not disturb it
    wr(1'b1, 8'd4); cur_div = 4;
    run_op(2'b10, 8'hC3, 1, 8'd5);
    // R8 next operation takes the divisor written while busy
    run_op(2'b01, 8'h7E, 0, 8'd0);
    // R9 command write with no bits set starts nothing
    wr(1'b0, 8'h00);
    chk("R9 empty command ignored", busy == 1'b0, busy, 0);
    repeat (20) @(negedge clk);
    chk("R9 still idle", busy == 1'b0 && cmd_bits == 2'b00, busy, 0);
    report();
  end
endmodule